// File: doc/BRIEF.md
# Near Branch Target Calculator

This block works out the next instruction pointer for near jumps and near calls in a core that runs mixed 16-bit and 32-bit code. It is given the pointer of the instruction that follows the branch, the default-size bit of the current code segment, and a flag that says whether an operand-size override prefix was seen. From these two bits it decides the effective operand size. That size, and not the address size, sets how wide the full immediate is and whether the result is cut to 16 bits.

Three kinds of branch are handled:

- Short relative branches carry an 8-bit displacement.
- Full relative branches carry an immediate whose width follows the operand size.
- Indirect branches take their target from a register or memory operand that has already been fetched.

Relative targets are formed by adding the sign-extended displacement to the pointer. Indirect targets are zero-extended and replace the pointer outright. A parameter chooses between a registered output stage with a one-cycle valid pipeline and a purely combinational path.

Top module: `branch_target_calc`

## Requirements
- R1: The effective operand size is 32-bit (`op32`=1) when exactly one of `cs_default32` and `opsize_prefix` is 1. Otherwise it is 16-bit (`op32`=0).
- R2: Form code 2'b00 (short relative) sign-extends `disp[7:0]` to 32 bits and adds it to `cur_ip`, whatever the operand size.
- R3: Form code 2'b01 (full relative) uses `disp[15:0]` sign-extended when the operand size is 16-bit, and all of `disp[31:0]` when it is 32-bit. The result is added to `cur_ip`.
- R4: Relative sums wrap modulo 2^32. A carry out of bit 31 is dropped.
- R5: When the operand size is 16-bit, bits 31..16 of the target are zero for every form. This is the sum or operand ANDed with 0x0000FFFF.
- R6: A form code with bit 1 set (2'b10 or 2'b11) is indirect. The target is `ind_operand`, zero-extended from 16 bits when the operand size is 16-bit, and `cur_ip` is not used.
- R7: With REG_OUT=1, `out_valid` equals `in_valid` delayed by one clock. `target` and `op32` show the result for that request.
- R8: With REG_OUT=1, a cycle with `in_valid` low leaves `target` and `op32` unchanged in the next cycle.
- R9: With REG_OUT=1, a synchronous active-high `rst` clears `out_valid`, `target` and `op32` to zero at the next clock edge.
- R10: With REG_OUT=0, the outputs follow the inputs in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| cur_ip | input | 32 | Pointer to the instruction after the branch |
| cs_default32 | input | 1 | Code segment default size is 32-bit |
| opsize_prefix | input | 1 | Operand-size override prefix present |
| form | input | 2 | 00 short relative, 01 full relative, 1x indirect |
| disp | input | 32 | Raw displacement, low bits used per form and size |
| ind_operand | input | 32 | Indirect target operand |
| out_valid | output | 1 | Result valid |
| target | output | 32 | Computed target pointer |
| op32 | output | 1 | Effective operand size is 32-bit |

## Verification
The assertions check on every cycle that the valid signal follows the request one clock later. They also check that a 16-bit result never has upper bits set, that idle cycles hold the result, that reset clears the stage, and that a 32-bit indirect target is the operand itself. Sign extension of each displacement width, wrap past 2^32 and the 16-bit cut after a carry out of bit 15 can only be shown by the bench. It sweeps every size and form combination over corner pointers and displacements, and compares against arithmetic done in integers.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int BT_AW = 32;
    localparam int BT_NW = 16;
    localparam int BT_SW = 8;

    typedef enum logic [1:0] {
        FORM_SHORT = 2'b00,
        FORM_FULL  = 2'b01,
        FORM_IND   = 2'b10,
        FORM_IND2  = 2'b11
    } bt_form_e;

    typedef struct packed {
        logic             vld;
        logic [BT_AW-1:0] tgt;
        logic             op32;
    } bt_out_t;
endpackage

// File: rtl/bt_opsize.sv
module bt_opsize (
    input  logic cs_default32,
    input  logic opsize_prefix,
    output logic op32
);
    // prefix toggles the segment default size
    always_comb begin
        op32 = cs_default32 ^ opsize_prefix;
    end
endmodule

// File: rtl/bt_operand_sel.sv
module bt_operand_sel #(
    parameter int AW = bt_pkg::BT_AW,
    parameter int NW = bt_pkg::BT_NW,
    parameter int SW = bt_pkg::BT_SW
) (
    input  logic [1:0]    form,
    input  logic          op32,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] ind_operand,
    output logic [AW-1:0] addend,
    output logic          use_ip
);
    localparam int SPAD = AW - SW;
    localparam int NPAD = AW - NW;

    logic [AW-1:0] short_ext;
    logic [AW-1:0] narrow_ext;
    logic [AW-1:0] ind_ext;

    always_comb begin
        short_ext  = {{SPAD{disp[SW-1]}}, disp[SW-1:0]};
        narrow_ext = {{NPAD{disp[NW-1]}}, disp[NW-1:0]};
        ind_ext    = op32 ? ind_operand : {{NPAD{1'b0}}, ind_operand[NW-1:0]};
        use_ip     = !form[1];
        if (form[1]) begin
            addend = ind_ext;
        end else if (form[0]) begin
            addend = op32 ? disp : narrow_ext;
        end else begin
            addend = short_ext;
        end
    end
endmodule

// File: rtl/bt_target.sv
module bt_target #(
    parameter int AW = bt_pkg::BT_AW,
    parameter int NW = bt_pkg::BT_NW
) (
    input  logic [AW-1:0] cur_ip,
    input  logic [AW-1:0] addend,
    input  logic          use_ip,
    input  logic          op32,
    output logic [AW-1:0] tgt
);
    localparam int NPAD = AW - NW;

    logic [AW-1:0] base;
    logic [AW-1:0] sum;

    always_comb begin
        base = use_ip ? cur_ip : '0;
        sum  = base + addend;        // carry out of the top bit is dropped
        tgt  = op32 ? sum : {{NPAD{1'b0}}, sum[NW-1:0]};
    end
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc
    import bt_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BT_AW-1:0] cur_ip,
    input  logic             cs_default32,
    input  logic             opsize_prefix,
    input  logic [1:0]       form,
    input  logic [BT_AW-1:0] disp,
    input  logic [BT_AW-1:0] ind_operand,
    output logic             out_valid,
    output logic [BT_AW-1:0] target,
    output logic             op32
);
    logic             op32_c;
    logic [BT_AW-1:0] addend_c;
    logic             use_ip_c;
    logic [BT_AW-1:0] tgt_c;

    bt_opsize u_opsize (
        .cs_default32 (cs_default32),
        .opsize_prefix(opsize_prefix),
        .op32         (op32_c)
    );

    bt_operand_sel #(.AW(BT_AW), .NW(BT_NW), .SW(BT_SW)) u_sel (
        .form       (form),
        .op32       (op32_c),
        .disp       (disp),
        .ind_operand(ind_operand),
        .addend     (addend_c),
        .use_ip     (use_ip_c)
    );

    bt_target #(.AW(BT_AW), .NW(BT_NW)) u_tgt (
        .cur_ip(cur_ip),
        .addend(addend_c),
        .use_ip(use_ip_c),
        .op32  (op32_c),
        .tgt   (tgt_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            bt_out_t out_d;
            bt_out_t out_q;

            always_comb begin
                out_d     = out_q;
                out_d.vld = in_valid;
                if (in_valid) begin
                    out_d.tgt  = tgt_c;
                    out_d.op32 = op32_c;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end

            assign out_valid = out_q.vld;
            assign target    = out_q.tgt;
            assign op32      = out_q.op32;

            // R7: valid follows the request one clock later
            assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R8: an idle cycle keeps the result
            assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(target) && $stable(op32)));
            // R9: reset clears the stage
            assert_reset_clear_R9: assert property (@(posedge clk)
                rst |=> (!out_valid && target == '0 && !op32));
            // R5: a 16-bit result has no upper bits
            assert_narrow_mask_R5: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !op32) |-> (target[BT_AW-1:BT_NW] == '0));
            // R6: a 32-bit indirect target is the operand unchanged
            assert_ind_wide_R6: assert property (@(posedge clk) disable iff (rst)
                (in_valid && form[1] && (cs_default32 != opsize_prefix))
                |=> (target == $past(ind_operand)));
            // R1: size flag matches the size bits of the request
            assert_opsize_R1: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (op32 == ($past(cs_default32) ^ $past(opsize_prefix))));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign target    = tgt_c;
            assign op32      = op32_c;
        end
    endgenerate
endmodule

// File: tb/branch_target_calc_tb.sv
module branch_target_calc_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] cur_ip;
    logic        cs_default32;
    logic        opsize_prefix;
    logic [1:0]  form;
    logic [31:0] disp;
    logic [31:0] ind_operand;
    logic        out_valid, op32;
    logic [31:0] target;
    logic        c_valid, c_op32;
    logic [31:0] c_target;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_target_calc #(.REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cur_ip(cur_ip),
        .cs_default32(cs_default32), .opsize_prefix(opsize_prefix),
        .form(form), .disp(disp), .ind_operand(ind_operand),
        .out_valid(out_valid), .target(target), .op32(op32));

    branch_target_calc #(.REG_OUT(1'b0)) u_dut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cur_ip(cur_ip),
        .cs_default32(cs_default32), .opsize_prefix(opsize_prefix),
        .form(form), .disp(disp), .ind_operand(ind_operand),
        .out_valid(c_valid), .target(c_target), .op32(c_op32));

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint expect_tgt(input longint ip, input longint d,
                                          input longint ind, input int f, input bit w32);
        longint e;
        longint s;
        if (f >= 2) begin
            s = w32 ? ind : (ind % 65536);
            return s;
        end
        if (f == 0) begin
            e = d % 256;
            if (e >= 128) e = e - 256;
        end else if (!w32) begin
            e = d % 65536;
            if (e >= 32768) e = e - 65536;
        end else begin
            e = d;
            if (e >= 64'd2147483648) e = e - 64'd4294967296;
        end
        s = (ip + e + 64'd4294967296) % 64'd4294967296;
        if (!w32) s = s % 65536;
        return s;
    endfunction

    longint ips [5]  = '{0, 64'h0000FFFF, 64'h1234FFF0, 64'hFFFFFFF0, 64'h00008000};
    longint dsps [9] = '{0, 64'h7F, 64'h80, 64'hFF, 64'h7FFF, 64'h8000,
                         64'hFFFFFFFF, 64'h80000000, 64'h12345678};

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; cur_ip = 0; cs_default32 = 0; opsize_prefix = 0;
        form = 0; disp = 0; ind_operand = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset valid", out_valid, 0);
        chk("R9 reset target", target, 0);
        chk("R9 reset op32", op32, 0);
        rst = 0;

        for (int c = 0; c < 2; c++)
        for (int p = 0; p < 2; p++)
        for (int f = 0; f < 4; f++)
        for (int i = 0; i < 5; i++)
        for (int j = 0; j < 9; j++) begin
            bit w;
            longint ind;
            longint exp;
            string tag;
            w   = (c != p);
            ind = dsps[j] ^ 64'hA5A5A5A5;
            exp = expect_tgt(ips[i], dsps[j], ind, f, w);
            tag = (f == 0) ? "R2/R4" : (f == 1) ? "R3/R4" : "R6";
            if (!w) tag = {tag, "/R5"};
            in_valid = 1; cur_ip = ips[i][31:0]; cs_default32 = c[0];
            opsize_prefix = p[0]; form = f[1:0]; disp = dsps[j][31:0];
            ind_operand = ind[31:0];
            #1;
            chk("R10 comb valid", c_valid, 1);
            chk({"R10 comb ", tag}, c_target, exp);
            @(negedge clk);
            chk("R7 valid", out_valid, 1);
            chk({"target ", tag}, target, exp);
            chk("R1 op32", op32, w);
            if (i == 3 && j == 8) begin
                // idle cycle with changed inputs: result must hold
                in_valid = 0; cur_ip = 32'h0BADF00D; disp = 32'h00000042;
                ind_operand = 32'h87654321; opsize_prefix = ~p[0];
                #1;
                chk("R10 comb idle valid", c_valid, 0);
                @(negedge clk);
                chk("R7 idle valid", out_valid, 0);
                chk("R8 hold target", target, exp);
                chk("R8 hold op32", op32, w);
            end
        end

        // reset while a request is present
        in_valid = 1; cur_ip = 32'h00001000; form = 2'b00; disp = 32'h10;
        rst = 1;
        @(negedge clk);
        chk("R9 reset over request valid", out_valid, 0);
        chk("R9 reset over request target", target, 0);
        rst = 0; in_valid = 0;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule